// File: doc/BRIEF.md
# PC-Indexed Stride Prefetcher

This block watches the load stream of a core. Each load arrives with its instruction PC and its data address. The block keeps a small table, selected by the low bits of the PC. For each load instruction the table remembers the address it last touched, the distance between its last two addresses, and a saturating confidence count. Once the same distance has been seen often enough, every further access from that PC sends a prefetch request. The request targets the address a fixed number of strides ahead of the current one, so the memory latency is covered before the demand stream gets there.

Returned prefetch data does not go into the cache. It goes into a small fully-associative buffer that is filled in first-in, first-out order. Demand addresses are looked up in this buffer in the same cycle. A hit returns the stored word and releases the slot, so a line that was prefetched but not yet used never displaces cache contents.

Top module: `stride_prefetcher`

## Requirements
- R1: After synchronous reset the table and the buffer are empty: `pf_req_valid` is 0 and every lookup misses.
- R2: The table index is `acc_pc[3:0]` and the tag is `acc_pc[9:4]`. The first access to an index, or an access whose tag differs from the stored tag, claims the entry: it records the address, sets stride 0 and confidence 0, and issues no prefetch.
- R3: On a tag match the new stride is `acc_addr` minus the recorded address. A stride equal to the stored one increments confidence, saturating at 3. A different stride sets confidence to 1 and stores the new stride. A prefetch is issued only when the updated confidence is 2 or more, so a constant stride first prefetches on the third access of a freshly claimed PC.
- R4: A prefetch request appears on `pf_req_valid`/`pf_req_addr` one cycle after the access that causes it. Its address is `acc_addr + stride * DIST`, where DIST defaults to 2.
- R5: An access whose computed stride is zero never issues a prefetch, whatever the confidence.
- R6: A fill is stored in the buffer. A later lookup of that address raises `dem_hit` in the same cycle, combinationally, with the filled word on `dem_data`.
- R7: A lookup hit releases its slot at the next clock edge, so an immediate second lookup of the same address misses.
- R8: A fill of a new address goes to the slot after the one filled last, in round-robin order over the 4 slots. When all 4 slots are valid, this overwrites the oldest fill.
- R9: A fill whose address is already held replaces that slot's data in place. The round-robin position does not move, and no second copy is created.
- R10: A lookup miss, or no lookup at all, gives `dem_hit` = 0 and `dem_data` = 0.
- R11: Stride and prefetch arithmetic is modulo 2^ADDR_W. Negative strides work, and a target below zero wraps around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A load access is presented |
| acc_pc | input | PC_W | PC of the load instruction |
| acc_addr | input | ADDR_W | Data address of the load |
| pf_req_valid | output | 1 | Prefetch request issued |
| pf_req_addr | output | ADDR_W | Address to prefetch |
| fill_valid | input | 1 | Prefetched data returns |
| fill_addr | input | ADDR_W | Address of the returned word |
| fill_data | input | DATA_W | Returned word |
| dem_valid | input | 1 | Demand lookup into the buffer |
| dem_addr | input | ADDR_W | Demand address |
| dem_hit | output | 1 | Demand address is held in the buffer |
| dem_data | output | DATA_W | Word for a hit, zero otherwise |

## Verification
The embedded properties check four things on every cycle:
- no request follows a claiming access, a zero stride or a broken stride;
- a request always follows an access;
- no two buffer slots ever hold the same address;
- a hit slot is empty afterwards unless a fill rewrote it.

Only the bench scenarios can show the rest:
- the exact prefetch target for positive and negative strides;
- the moment confidence first crosses the threshold;
- oldest-first replacement, in-place refresh, and data returned from the buffer.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;

    typedef logic [1:0] conf_t;

    localparam conf_t CONF_ZERO  = 2'd0;
    localparam conf_t CONF_SEEN  = 2'd1;
    localparam conf_t CONF_ISSUE = 2'd2;
    localparam conf_t CONF_MAX   = 2'd3;

    // Confidence after one more observed stride
    function automatic conf_t conf_step(input conf_t cur, input logic same);
        if (!same)
            return CONF_SEEN;
        else if (cur == CONF_MAX)
            return cur;
        else
            return cur + 2'd1;
    endfunction

    function automatic logic conf_ready(input conf_t c);
        return c >= CONF_ISSUE;
    endfunction

endpackage

// File: rtl/stride_table.sv
module stride_table
    import stride_pf_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 6,
    parameter int DIST    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [PC_W-1:0]   acc_pc,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [ADDR_W-1:0] DIST_V = ADDR_W'(DIST);

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] last;
        logic [ADDR_W-1:0] stride;
        conf_t             conf;
    } entry_t;

    entry_t            tbl_q [ENTRIES];
    entry_t            cur_e;
    entry_t            nxt_e;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic              tag_hit;
    logic              stride_eq;
    logic              issue;
    logic [ADDR_W-1:0] new_stride;

    assign idx = acc_pc[IDX_W-1:0];
    assign tag = acc_pc[IDX_W +: TAG_W];

    always_comb begin
        cur_e      = tbl_q[idx];
        tag_hit    = cur_e.valid && (cur_e.tag == tag);
        new_stride = acc_addr - cur_e.last;
        stride_eq  = (new_stride == cur_e.stride);
        nxt_e      = cur_e;
        if (!tag_hit) begin
            nxt_e.valid  = 1'b1;
            nxt_e.tag    = tag;
            nxt_e.last   = acc_addr;
            nxt_e.stride = '0;
            nxt_e.conf   = CONF_ZERO;
        end else begin
            nxt_e.last   = acc_addr;
            nxt_e.stride = new_stride;
            nxt_e.conf   = conf_step(cur_e.conf, stride_eq);
        end
        issue = acc_valid && tag_hit && conf_ready(nxt_e.conf) && (new_stride != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
            pf_valid <= 1'b0;
            pf_addr  <= '0;
        end else begin
            pf_valid <= issue;
            if (issue) pf_addr <= acc_addr + new_stride * DIST_V;
            if (acc_valid) tbl_q[idx] <= nxt_e;
        end
    end

    assert_alloc_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !tag_hit) |=> !pf_valid);

    assert_zero_stride_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && tag_hit && new_stride == '0) |=> !pf_valid);

    assert_broken_stride_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && tag_hit && !stride_eq) |=> !pf_valid);

    assert_req_after_access_R4: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> $past(acc_valid));

endmodule

// File: rtl/pf_buffer.sv
module pf_buffer #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              dem_valid,
    input  logic [ADDR_W-1:0] dem_addr,
    output logic              dem_hit,
    output logic [DATA_W-1:0] dem_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]  valid_q;
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [PTR_W-1:0]  wptr_q;

    logic [DEPTH-1:0]  hit_vec;
    logic [DEPTH-1:0]  same_vec;
    logic [DEPTH-1:0]  wr_vec;
    logic              fill_present;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g]  = dem_valid && valid_q[g] && (addr_q[g] == dem_addr);
        assign same_vec[g] = valid_q[g] && (addr_q[g] == fill_addr);
    end

    assign fill_present = |same_vec;

    always_comb begin
        wr_vec = '0;
        if (fill_valid) begin
            if (fill_present) wr_vec = same_vec;
            else              wr_vec[wptr_q] = 1'b1;
        end
    end

    always_comb begin
        dem_data = '0;
        for (int i = 0; i < DEPTH; i++)
            if (hit_vec[i]) dem_data = dem_data | data_q[i];
    end
    assign dem_hit = |hit_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            wptr_q  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                addr_q[i] <= '0;
                data_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_vec[i]) begin
                    valid_q[i] <= 1'b1;
                    addr_q[i]  <= fill_addr;
                    data_q[i]  <= fill_data;
                end else if (hit_vec[i]) begin
                    valid_q[i] <= 1'b0;
                end
            end
            if (fill_valid && !fill_present)
                wptr_q <= (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
        end
    end

    assert_single_copy_R9: assert property (@(posedge clk) disable iff (rst)
        $countones(same_vec) <= 1 && $countones(hit_vec) <= 1);

    assert_hit_released_R7: assert property (@(posedge clk) disable iff (rst)
        (|(hit_vec & ~wr_vec)) |=> ((valid_q & $past(hit_vec & ~wr_vec)) == '0));

endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher #(
    parameter int PC_W      = 32,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int TBL_ENTRIES = 16,
    parameter int TAG_W     = 6,
    parameter int BUF_DEPTH = 4,
    parameter int DIST      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [PC_W-1:0]   acc_pc,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              pf_req_valid,
    output logic [ADDR_W-1:0] pf_req_addr,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              dem_valid,
    input  logic [ADDR_W-1:0] dem_addr,
    output logic              dem_hit,
    output logic [DATA_W-1:0] dem_data
);
    stride_table #(
        .PC_W(PC_W), .ADDR_W(ADDR_W), .ENTRIES(TBL_ENTRIES),
        .TAG_W(TAG_W), .DIST(DIST)
    ) u_table (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_pc(acc_pc), .acc_addr(acc_addr),
        .pf_valid(pf_req_valid), .pf_addr(pf_req_addr)
    );

    pf_buffer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(BUF_DEPTH)
    ) u_buf (
        .clk(clk), .rst(rst),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .dem_valid(dem_valid), .dem_addr(dem_addr),
        .dem_hit(dem_hit), .dem_data(dem_data)
    );

    assert_miss_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !dem_hit |-> dem_data == '0);

endmodule

// File: tb/stride_prefetcher_test.sv
module stride_prefetcher_test;
    localparam int CLK_PERIOD = 10;
    localparam int NSLOT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_pc = '0;
    logic [31:0] acc_addr = '0;
    logic        pf_req_valid;
    logic [31:0] pf_req_addr;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_addr = '0;
    logic [31:0] fill_data = '0;
    logic        dem_valid = 1'b0;
    logic [31:0] dem_addr = '0;
    logic        dem_hit;
    logic [31:0] dem_data;

    stride_prefetcher uut (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_pc(acc_pc), .acc_addr(acc_addr),
        .pf_req_valid(pf_req_valid), .pf_req_addr(pf_req_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .dem_valid(dem_valid), .dem_addr(dem_addr),
        .dem_hit(dem_hit), .dem_data(dem_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    string phase = "R1";

    // reference state: table keyed by index, buffer slots with fill order
    bit          m_v [int];
    int          m_tag [int];
    logic [31:0] m_last [int];
    logic [31:0] m_str [int];
    int          m_conf [int];
    bit          b_v [NSLOT];
    logic [31:0] b_a [NSLOT];
    logic [31:0] b_d [NSLOT];
    int          b_wp = 0;
    bit          exp_pfv = 0;
    logic [31:0] exp_pfa = '0;

    task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", phase, what, got, exp);
        end
    endtask

    task automatic step(input bit av, input logic [31:0] apc, input logic [31:0] aad,
                        input bit fv, input logic [31:0] fa, input logic [31:0] fd,
                        input bit lv, input logic [31:0] la);
        bit e_hit = 0;
        logic [31:0] e_data = '0;
        int hs = -1;
        int fs = -1;
        bit npfv = 0;
        logic [31:0] npa = '0;
        acc_valid = av; acc_pc = apc; acc_addr = aad;
        fill_valid = fv; fill_addr = fa; fill_data = fd;
        dem_valid = lv; dem_addr = la;
        #1;
        for (int i = 0; i < NSLOT; i++) begin
            if (lv && b_v[i] && b_a[i] == la) begin
                e_hit = 1; e_data = b_d[i]; hs = i;
            end
            if (b_v[i] && b_a[i] == fa) fs = i;
        end
        check("dem_hit", {31'b0, dem_hit}, {31'b0, e_hit});
        check("dem_data", dem_data, e_data);
        check("pf_req_valid", {31'b0, pf_req_valid}, {31'b0, exp_pfv});
        if (exp_pfv) check("pf_req_addr", pf_req_addr, exp_pfa);
        if (av) begin
            int ix = int'(apc % 16);
            int tg = int'((apc >> 4) % 64);
            if (!m_v.exists(ix) || m_tag[ix] != tg) begin
                m_v[ix] = 1; m_tag[ix] = tg; m_last[ix] = aad; m_str[ix] = 0; m_conf[ix] = 0;
            end else begin
                logic [31:0] ns = aad - m_last[ix];
                if (ns == m_str[ix]) m_conf[ix] = (m_conf[ix] >= 3) ? 3 : m_conf[ix] + 1;
                else m_conf[ix] = 1;
                m_str[ix] = ns; m_last[ix] = aad;
                npfv = (m_conf[ix] >= 2) && (ns != 0);
                npa = aad + ns * 2;
            end
        end
        if (hs >= 0) b_v[hs] = 0;
        if (fv) begin
            int w = (fs >= 0) ? fs : b_wp;
            b_v[w] = 1; b_a[w] = fa; b_d[w] = fd;
            if (fs < 0) b_wp = (b_wp + 1) % NSLOT;
        end
        @(posedge clk);
        exp_pfv = npfv; exp_pfa = npa;
        @(negedge clk);
    endtask

    task automatic acc(input logic [31:0] pc, input logic [31:0] a);
        step(1, pc, a, 0, 0, 0, 0, 0);
    endtask

    task automatic fill(input logic [31:0] a, input logic [31:0] d);
        step(0, 0, 0, 1, a, d, 0, 0);
    endtask

    task automatic look(input logic [31:0] a);
        step(0, 0, 0, 0, 0, 0, 1, a);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NSLOT; i++) b_v[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        phase = "R1";
        look(32'h0); look(32'h1000);
        step(0, 0, 0, 0, 0, 0, 0, 0);

        phase = "R3";   // constant stride +8 from PC 0x100
        for (int k = 0; k < 6; k++) acc(32'h100, 32'h1000 + 32'(k * 8));
        phase = "R4";   // stride change breaks, then rebuilds
        acc(32'h100, 32'h1100);
        acc(32'h100, 32'h1140);
        acc(32'h100, 32'h1180);
        acc(32'h100, 32'h11C0);
        step(0, 0, 0, 0, 0, 0, 0, 0);

        phase = "R5";   // zero stride
        for (int k = 0; k < 5; k++) acc(32'h204, 32'h8000);
        step(0, 0, 0, 0, 0, 0, 0, 0);

        phase = "R11";  // negative stride wrapping below zero
        acc(32'h3A8, 32'h10);
        acc(32'h3A8, 32'h0C);
        acc(32'h3A8, 32'h08);
        acc(32'h3A8, 32'h04);
        acc(32'h3A8, 32'h00);
        step(0, 0, 0, 0, 0, 0, 0, 0);

        phase = "R2";   // alias at index 0 with a different tag
        acc(32'h140, 32'h5000);
        acc(32'h100, 32'h1200);
        acc(32'h100, 32'h1210);
        acc(32'h100, 32'h1220);
        acc(32'h140, 32'h5004);
        // interleaved PCs at separate indices
        for (int k = 0; k < 4; k++) begin
            acc(32'h111, 32'h2000 + 32'(k * 32));
            acc(32'h222, 32'h9000 + 32'(k * 4));
        end
        step(0, 0, 0, 0, 0, 0, 0, 0);

        phase = "R6";
        fill(32'hA0, 32'hDEAD0001);
        look(32'hA0);
        phase = "R7";
        look(32'hA0);
        phase = "R10";
        look(32'hB0);
        step(0, 0, 0, 0, 0, 0, 0, 0);

        phase = "R8";   // five fills into four slots
        for (int k = 0; k < 5; k++) fill(32'h400 + 32'(k * 4), 32'hC0DE0000 + 32'(k));
        for (int k = 0; k < 5; k++) look(32'h400 + 32'(k * 4));

        phase = "R9";   // refresh in place
        fill(32'h600, 32'h11111111);
        fill(32'h600, 32'h22222222);
        look(32'h600);
        look(32'h600);
        // fill and lookup in the same cycle, while loads stream
        fill(32'h700, 32'h33);
        step(1, 32'h100, 32'h1230, 1, 32'h704, 32'h44, 1, 32'h700);
        step(1, 32'h100, 32'h1240, 1, 32'h700, 32'h55, 1, 32'h704);
        step(1, 32'h100, 32'h1250, 0, 0, 0, 1, 32'h700);
        step(0, 0, 0, 0, 0, 0, 0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule